// File: doc/BRIEF.md
# Bit-Band Alias Translator

This block sits between a 32-bit processor-side request port and a memory or peripheral bus. Two 32 MiB alias windows are decoded. Each 32-bit word inside a window stands for one bit of a target region. An alias read returns that bit as 0 or 1. An alias write becomes a locked read-modify-write of the byte, halfword or word that holds the bit. The write sets or clears only the selected bit and leaves every other bit of the unit as it was.

The windows are placed by parameters. By default, alias base 0x2200_0000 maps onto region base 0x2000_0000 and alias base 0x4200_0000 maps onto region base 0x4000_0000. An address outside both windows goes to the downstream port unchanged. The block handles one request at a time. A requester holds `req_i` until `ready_o` pulses for one cycle, then drops it.

Top module: `bitband_xlat`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `ready_o`, `mreq_o` and `mlock_o` are low.
- R2: An address whose top 7 bits equal those of an alias base is an alias access. Its target byte address is the matching region base ORed with bits [24:5] of the request address, placed at bits [19:0].
- R3: Size codes are 0 = byte, 1 = halfword, 2 = word. A byte access selects bit `addr[4:2]` of the target byte. A halfword access clears target bit 0 and selects bit `addr[5:2]`. A word access clears target bits [1:0] and selects bit `addr[6:2]`. Lanes are little-endian, so byte lane k carries data bits [8k+7:8k].
- R4: An alias read issues exactly one downstream read, with `mlock_o` low. It returns the selected bit in `rdata_o[0]`, and all other `rdata_o` bits are zero.
- R5: An alias write sets the selected bit when `wdata_i[0]` is 1 and clears it when `wdata_i[0]` is 0. `wdata_i[31:1]` has no effect, and no other bit of the unit changes.
- R6: An alias write issues a downstream read and then a write to the same address and byte enables. `mreq_o` stays high between them with no gap, and `mlock_o` is high throughout. No other downstream transaction comes between the two.
- R7: `mbe_o` is `1<<a[1:0]` for bytes, `3<<{a[1],1'b0}` for halfwords and `4'hF` for words, where `a` is `maddr_o`.
- R8: `ready_o` is high for exactly one cycle, the cycle after the last downstream completion of the request. No downstream request is active while `ready_o` is high.
- R9: A request outside both windows is passed through as one downstream transaction. It keeps the original address, direction and write data, uses the byte enables of R7, and keeps `mlock_o` low. For a read, `rdata_o` returns `mrdata_i` unchanged.
- R10: An alias write completes with `rdata_o` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Request byte address |
| size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data; bit 0 used by alias writes |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read result, valid with ready_o |
| mreq_o | output | 1 | Downstream request, held until mready_i |
| mwe_o | output | 1 | Downstream write strobe |
| maddr_o | output | 32 | Downstream byte address |
| mbe_o | output | 4 | Downstream byte enables |
| mwdata_o | output | 32 | Downstream write data |
| mlock_o | output | 1 | Locked sequence in progress |
| mready_i | input | 1 | Downstream completion, one cycle |
| mrdata_i | input | 32 | Downstream read data, valid with mready_i |

## Verification
The assertions assume a well-behaved downstream port. `mready_i` is high for only one cycle per request, is asserted only while `mreq_o` is high, and presents read data in that same cycle. On the upstream side, the requester holds its fields stable until `ready_o` and then drops `req_i`. The bench's memory responder raises `mready_i` once per request after a random wait of 0 to 3 cycles and lowers it the next cycle. The requester tasks release `req_i` on the falling edge at which they observe `ready_o`, so neither contract is broken.

// File: rtl/bitband_pkg.sv
package bitband_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BIT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE, ST_RESP} seq_state_e;

  function automatic logic [3:0] lane_enables(logic [1:0] sz, logic [1:0] a);
    case (sz)
      2'd0:    return 4'b0001 << a;
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/bitband_win_decode.sv
module bitband_win_decode #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_BITS = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] taddr_o
);
  // 4 alias bytes per bit, 8 bits per byte
  localparam int unsigned SHIFT = 5;
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

  logic [NUM_WIN-1:0]  win_hit;
  logic [ADDR_W-1:0]   cand [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign win_hit[w] = addr_i[ADDR_W-1:WIN_BITS] == ALIAS_BASES[w*ADDR_W+WIN_BITS +: TAG_W];
    assign cand[w]    = REGION_BASES[w*ADDR_W +: ADDR_W]
                        | ADDR_W'(addr_i[WIN_BITS-1:SHIFT]);
  end

  always_comb begin
    hit_o   = 1'b0;
    taddr_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        hit_o   = 1'b1;
        taddr_o = cand[w];
      end
    end
  end
endmodule

// File: rtl/bitband_lane_map.sv
module bitband_lane_map
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              alias_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] taddr_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [3:0]        be_o,
  output logic [BIT_W-1:0]  bitpos_o
);
  logic [ADDR_W-1:0] unit_addr;

  always_comb begin
    case (acc_size_e'(size_i))
      SZ_BYTE: begin
        unit_addr = taddr_i;
        bitpos_o  = {taddr_i[1:0], addr_i[4:2]};
      end
      SZ_HALF: begin
        unit_addr = {taddr_i[ADDR_W-1:1], 1'b0};
        bitpos_o  = {taddr_i[1], addr_i[5:2]};
      end
      default: begin
        unit_addr = {taddr_i[ADDR_W-1:2], 2'b00};
        bitpos_o  = addr_i[6:2];
      end
    endcase
    maddr_o = alias_i ? unit_addr : addr_i;
    be_o    = lane_enables(size_i, maddr_o[1:0]);
  end
endmodule

// File: rtl/bitband_seq.sv
module bitband_seq
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [1:0]        size_q_o,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] xaddr_i,
  input  logic [3:0]        be_i,
  input  logic [BIT_W-1:0]  bitpos_i,
  output logic              mreq_o,
  output logic              mwe_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [3:0]        mbe_o,
  output logic [DATA_W-1:0] mwdata_o,
  output logic              mlock_o,
  input  logic              mready_i,
  input  logic [DATA_W-1:0] mrdata_i
);
  seq_state_e        state_q, state_d;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, resp_q, wb_q;
  logic              done;

  assign done = (state_q == ST_FETCH || state_q == ST_STORE) && mready_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_FETCH;
      ST_FETCH: if (mready_i) state_d = (hit_i && we_q) ? ST_STORE : ST_RESP;
      ST_STORE: if (mready_i) state_d = ST_RESP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      addr_q_o <= '0;
      size_q_o <= '0;
      wdata_q  <= '0;
      resp_q   <= '0;
      wb_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        we_q     <= we_i;
        addr_q_o <= addr_i;
        size_q_o <= size_i;
        wdata_q  <= wdata_i;
      end
      if (state_q == ST_FETCH && mready_i) begin
        if (!hit_i) begin
          resp_q <= mrdata_i;
        end else if (!we_q) begin
          resp_q <= DATA_W'(mrdata_i[bitpos_i]);
        end else begin
          resp_q             <= '0;
          wb_q               <= mrdata_i;
          wb_q[bitpos_i]     <= wdata_q[0];
        end
      end
    end
  end

  logic unused;
  assign unused = done;

  assign ready_o  = state_q == ST_RESP;
  assign rdata_o  = resp_q;
  assign mreq_o   = state_q == ST_FETCH || state_q == ST_STORE;
  assign mwe_o    = state_q == ST_STORE || (state_q == ST_FETCH && !hit_i && we_q);
  assign maddr_o  = xaddr_i;
  assign mbe_o    = be_i;
  assign mwdata_o = (state_q == ST_STORE) ? wb_q : wdata_q;
  assign mlock_o  = mreq_o && hit_i && we_q;
endmodule

// File: rtl/bitband_xlat.sv
module bitband_xlat
  import bitband_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_BITS = 25,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mreq_o,
  output logic              mwe_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [3:0]        mbe_o,
  output logic [DATA_W-1:0] mwdata_o,
  output logic              mlock_o,
  input  logic              mready_i,
  input  logic [DATA_W-1:0] mrdata_i
);
  logic [ADDR_W-1:0] addr_q, taddr, xaddr;
  logic [1:0]        size_q;
  logic              hit;
  logic [3:0]        be;
  logic [BIT_W-1:0]  bitpos;

  bitband_win_decode #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS),
    .ALIAS_BASES(ALIAS_BASES), .REGION_BASES(REGION_BASES)
  ) u_dec (
    .addr_i(addr_q), .hit_o(hit), .taddr_o(taddr)
  );

  bitband_lane_map #(.ADDR_W(ADDR_W)) u_lane (
    .alias_i(hit), .addr_i(addr_q), .taddr_i(taddr), .size_i(size_q),
    .maddr_o(xaddr), .be_o(be), .bitpos_o(bitpos)
  );

  bitband_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .ready_o, .rdata_o,
    .addr_q_o(addr_q), .size_q_o(size_q),
    .hit_i(hit), .xaddr_i(xaddr), .be_i(be), .bitpos_i(bitpos),
    .mreq_o, .mwe_o, .maddr_o, .mbe_o, .mwdata_o, .mlock_o,
    .mready_i, .mrdata_i
  );
endmodule

// File: rtl/bitband_xlat_chk.sv
module bitband_xlat_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              mreq_o,
  input logic              mwe_o,
  input logic [ADDR_W-1:0] maddr_o,
  input logic [3:0]        mbe_o,
  input logic [31:0]       mwdata_o,
  input logic              mlock_o,
  input logic              mready_i,
  input logic [31:0]       mrdata_i
);
  logic [31:0] rd_q, lane_mask;

  assign lane_mask = {{8{mbe_o[3]}}, {8{mbe_o[2]}}, {8{mbe_o[1]}}, {8{mbe_o[0]}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (mreq_o && mready_i && mlock_o && !mwe_o) rd_q <= mrdata_i;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_quiet_in_reset: assert (!ready_o && !mreq_o && !mlock_o);
  end

  a_r6_locked_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o && mready_i && mlock_o && !mwe_o |=>
      mreq_o && mwe_o && mlock_o && maddr_o == $past(maddr_o) && mbe_o == $past(mbe_o));

  a_r6_hold_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o && !mready_i |=>
      mreq_o && $stable(maddr_o) && $stable(mwe_o) && $stable(mlock_o));

  a_r5_single_bit_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o && mwe_o && mlock_o |-> $countones((mwdata_o ^ rd_q) & lane_mask) <= 1);

  a_r8_ready_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r8_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(mreq_o && mready_i) && !mreq_o);

  a_r7_be_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_o |-> mbe_o inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF});
endmodule

bind bitband_xlat bitband_xlat_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .ready_o, .mreq_o, .mwe_o, .maddr_o, .mbe_o,
  .mwdata_o, .mlock_o, .mready_i, .mrdata_i
);

// File: tb/tb_bitband_xlat.sv
module tb_bitband_xlat;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, mready_i = 0;
  logic [31:0] addr_i = 0, wdata_i = 0, mrdata_i = 0;
  logic [1:0]  size_i = 0;
  logic ready_o, mreq_o, mwe_o, mlock_o;
  logic [31:0] rdata_o, maddr_o, mwdata_o;
  logic [3:0]  mbe_o;

  always #4 clk_i = ~clk_i;

  bitband_xlat dut (.*);

  typedef struct {logic we; logic [31:0] addr; logic [3:0] be; logic lock; logic [31:0] wd;} txn_t;
  txn_t txq[$];
  logic [7:0] dmem [logic [31:0]];
  logic [7:0] rmem [logic [31:0]];
  int n_cmp = 0, n_bad = 0;
  bit pending = 0, finished = 0;

  function automatic logic [7:0] init_b(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] dget(logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : init_b(a);
  endfunction
  function automatic logic [7:0] rget(logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : init_b(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // downstream memory responder
  initial begin
    int wait_n = 0;
    forever begin
      @(negedge clk_i);
      if (mready_i) mready_i = 0;
      else if (mreq_o) begin
        if (wait_n > 0) wait_n--;
        else begin
          logic [31:0] wa;
          wa = {maddr_o[31:2], 2'b00};
          txq.push_back('{mwe_o, maddr_o, mbe_o, mlock_o, mwdata_o});
          if (mwe_o) begin
            for (int k = 0; k < 4; k++) if (mbe_o[k]) dmem[wa + k] = mwdata_o[8*k +: 8];
          end
          mrdata_i = {dget(wa + 3), dget(wa + 2), dget(wa + 1), dget(wa)};
          mready_i = 1;
          wait_n = int'($urandom_range(0, 3));
        end
      end
    end
  end

  // per-clock: no activity without an outstanding request (R8)
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !pending && !finished)
      chk(!ready_o && !mreq_o, "R8 idle quiet", {30'b0, ready_o, mreq_o}, 32'h0);
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    logic [31:0] got, region, baddr, unit, tb, exp_a;
    logic [3:0]  exp_be;
    int nb;
    bit is_alias;
    @(negedge clk_i);
    txq.delete();
    pending = 1; req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    do @(negedge clk_i); while (!ready_o);
    got = rdata_o; req_i = 0; pending = 0;

    is_alias = (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
    if (is_alias) begin
      // R2 / R3 reference address arithmetic
      region = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
      baddr  = region + ((a & 32'h01FF_FFFF) >> 5);
      case (sz)
        2'd0: begin unit = baddr;           nb = int'(a >> 2) % 8;  exp_be = 4'b0001 << unit[1:0]; end
        2'd1: begin unit = baddr & ~32'h1;  nb = int'(a >> 2) % 16; exp_be = unit[1] ? 4'hC : 4'h3; end
        default: begin unit = baddr & ~32'h3; nb = int'(a >> 2) % 32; exp_be = 4'hF; end
      endcase
      tb = unit + 32'(nb / 8);
      if (!we) begin
        chk(txq.size() == 1, "R4 one txn", txq.size(), 1);
        if (txq.size() == 1) begin
          chk(!txq[0].we && !txq[0].lock, "R4 read unlocked", {txq[0].we, txq[0].lock}, 0);
          chk(txq[0].addr == unit, "R2 R3 target addr", txq[0].addr, unit);
          chk(txq[0].be == exp_be, "R7 be read", txq[0].be, exp_be);
        end
        exp_a = 32'(rget(tb)[nb % 8]);
        chk(got == exp_a, "R4 read bit", got, exp_a);
      end else begin
        chk(txq.size() == 2, "R6 two txns", txq.size(), 2);
        if (txq.size() == 2) begin
          chk(!txq[0].we && txq[0].lock && txq[1].we && txq[1].lock, "R6 locked rmw",
              {txq[0].we, txq[0].lock, txq[1].we, txq[1].lock}, 32'b0111);
          chk(txq[0].addr == unit && txq[1].addr == unit, "R6 R2 same addr", txq[1].addr, unit);
          chk(txq[0].be == exp_be && txq[1].be == exp_be, "R7 be rmw", txq[1].be, exp_be);
        end
        rmem[tb] = rget(tb);
        rmem[tb][nb % 8] = wd[0];
        chk(got == 0, "R10 write resp", got, 0);
      end
    end else begin
      exp_be = (sz == 0) ? (4'b0001 << a[1:0]) : (sz == 1) ? (a[1] ? 4'hC : 4'h3) : 4'hF;
      chk(txq.size() == 1, "R9 one txn", txq.size(), 1);
      if (txq.size() == 1) begin
        chk(txq[0].addr == a && txq[0].we == we && !txq[0].lock, "R9 pass addr", txq[0].addr, a);
        chk(txq[0].be == exp_be, "R7 R9 be", txq[0].be, exp_be);
        if (we) chk(txq[0].wd == wd, "R9 pass wdata", txq[0].wd, wd);
      end
      unit = {a[31:2], 2'b00};
      if (we) begin
        for (int k = 0; k < 4; k++) if (exp_be[k]) rmem[unit + k] = wd[8*k +: 8];
      end else begin
        exp_a = {rget(unit + 3), rget(unit + 2), rget(unit + 1), rget(unit)};
        chk(got == exp_a, "R9 pass rdata", got, exp_a);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!ready_o && !mreq_o && !mlock_o, "R1 in reset", {ready_o, mreq_o, mlock_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!ready_o && !mreq_o && !mlock_o, "R1 after reset", {ready_o, mreq_o, mlock_o}, 0);

    // directed: R2 R3 R4 boundaries
    access(0, 32'h2200_0000, 2'd0, 0);
    access(0, 32'h23FF_FFFC, 2'd0, 0);
    access(0, 32'h2200_007C, 2'd1, 0);
    access(0, 32'h2200_00FC, 2'd2, 0);
    access(0, 32'h4200_0044, 2'd2, 0);
    // R5: set/clear with noise in upper bits, check via read-back
    access(1, 32'h2200_0024, 2'd0, 32'hFFFF_FFFE);
    access(0, 32'h2200_0024, 2'd0, 0);
    access(1, 32'h2200_0024, 2'd0, 32'h0000_0001);
    access(0, 32'h2000_0000, 2'd2, 0);
    access(1, 32'h4200_01F8, 2'd1, 32'h8000_0001);
    access(1, 32'h4200_03FC, 2'd2, 32'h7FFF_FFFE);
    access(0, 32'h4000_0010, 2'd2, 0);
    // R9 outside windows
    access(1, 32'h2400_0003, 2'd0, 32'h5A00_0000);
    access(0, 32'h2400_0000, 2'd2, 0);
    access(1, 32'h1000_0002, 2'd1, 32'hBEEF_0000);
    access(0, 32'h1000_0000, 2'd2, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      int pick;
      pick = int'($urandom_range(0, 9));
      sz   = 2'($urandom_range(0, 2));
      a    = {7'h11, 25'($urandom_range(0, 4095)), 2'b00} ;
      a    = {($urandom_range(0, 1) != 0) ? 7'h11 : 7'h21, 6'b0, a[20:2], 2'b00};
      if (pick < 4) access(0, a, sz, 0);
      else if (pick < 8) access(1, a, sz, $urandom);
      else if (pick == 8) access(0, {a[31:25] == 7'h11 ? 8'h20 : 8'h40, 10'b0, a[15:4], 2'b00}, 2'd2, 0);
      else access(1, {8'h30, 24'($urandom_range(0, 255))}, 2'd0, $urandom);
    end

    foreach (rmem[k]) chk(dget(k) == rmem[k], "R5 memory image", {24'b0, dget(k)}, {24'b0, rmem[k]});
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule